// File: doc/BRIEF.md
# Two-Port Interleaving Converter Input Multiplexer

This block sits in front of a high-speed digital-to-analog converter. It takes two 10-bit data ports, A and B, and delivers one 10-bit word per full-rate clock to the converter latch. In the three interleaving modes, both ports are sampled together at half rate and are then played out one after the other, A first and B second. The half-rate phase comes from an internal divider or from an external phase input. In the two pick modes, a per-cycle select input chooses which port's word goes out. The two pick modes differ in the clock edge at which the select is taken relative to the data.

The mode is a static 3-bit code. The reset input has a programmable sense and acts synchronously inside the block. The internal divider is exported, together with an output-enable for the pad driver, in one mode only.

Top module: `dac_interleave_mux`

## Requirements
- R1: When `rst_pol` is 1, reset is asserted by `rst_in` = 0. When `rst_pol` is 0, reset is asserted by `rst_in` = 1.
- R2: After one clock edge with reset asserted, `dac_word` and `div_out` are 0. They stay 0 while reset is held.
- R3: The mode codes on `mode_sel` are as follows. 000 is interleave with exported divider. 001 is interleave on the internal divider. 010 is interleave on the external phase. 100 is early pick. 101 is late pick. Every other code behaves as early pick.
- R4: The internal divider is 0 in reset. It becomes 1 at the first edge after reset is released and then inverts on every edge.
- R5: `div_out_en` is 1 only in mode 000, and there `div_out` equals the internal divider. In all other modes `div_out_en` and `div_out` are 0.
- R6: In the interleave modes, every edge that leaves the phase at 0 samples both ports. The port A word appears on `dac_word` after the second following edge. The port B word appears after the third following edge.
- R7: In mode 001 the phase is the internal divider, and `div_in` has no effect on `dac_word`.
- R8: In modes 000 and 010 the phase after an edge is the value of `div_in` sampled at that edge.
- R9: In early pick, the value of `dac_word` after edge e+2 is the port B word of edge e if `pick_b` was 1 at edge e. Otherwise it is the port A word of edge e.
- R10: In late pick, `dac_word` after edge e+2 holds the port B word of edge e if `pick_b` was 1 at edge e+1. Otherwise it holds the port A word of edge e.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Full-rate clock |
| rst_in | input | 1 | Reset request, sense set by `rst_pol` |
| rst_pol | input | 1 | 1: reset active low, 0: reset active high |
| mode_sel | input | 3 | Static mode code |
| div_in | input | 1 | External half-rate phase |
| pick_b | input | 1 | Per-cycle port select for the pick modes (1 = port B) |
| a_data | input | 10 | Port A data word |
| b_data | input | 10 | Port B data word |
| dac_word | output | 10 | Registered word to the converter latch |
| div_out | output | 1 | Exported internal divider |
| div_out_en | output | 1 | Drive enable for `div_out` pad |

## Verification
A divider or phase register stuck or out of step swaps the A and B order on `dac_word` within one or two clocks of reset release. It can also repeat a port's word. A slip in the capture register shifts the words by a full pair, and the next compared word shows it. A select register tapped at the wrong stage makes the two pick modes look the same, which shows within three edges as the word of the wrong port. A missing clear is seen at the first reset check after a run that left nonzero data.

// File: rtl/dim_pkg.sv
package dim_pkg;
  typedef enum logic [2:0] {
    MD_ILV_EXPORT = 3'b000,
    MD_ILV_SELF   = 3'b001,
    MD_ILV_EXT    = 3'b010,
    MD_PICK_EARLY = 3'b100,
    MD_PICK_LATE  = 3'b101
  } mode_e;

  function automatic mode_e decode_mode(input logic [2:0] code);
    case (code)
      3'b000:  return MD_ILV_EXPORT;
      3'b001:  return MD_ILV_SELF;
      3'b010:  return MD_ILV_EXT;
      3'b101:  return MD_PICK_LATE;
      default: return MD_PICK_EARLY;
    endcase
  endfunction
endpackage

// File: rtl/dim_phase_gen.sv
module dim_phase_gen
  import dim_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  mode_e mode,
  input  logic  div_in,
  output logic  ph_q,
  output logic  div_q
);
  logic ext_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= 1'b0;
      ext_q <= 1'b0;
    end else begin
      div_q <= ~div_q;
      ext_q <= div_in;
    end
  end

  assign ph_q = (mode == MD_ILV_SELF) ? div_q : ext_q;

  AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (div_q != $past(div_q))); // R4
endmodule

// File: rtl/dim_capture.sv
module dim_capture #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ilv,
  input  logic         ph_q,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] ia,
  output logic [W-1:0] ib
);
  logic [W-1:0] ra, rb;
  logic         take;

  assign take = !ilv || !ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ra <= '0;
      rb <= '0;
      ia <= '0;
      ib <= '0;
    end else begin
      ra <= a_in;
      rb <= b_in;
      if (take) begin
        ia <= ra;
        ib <= rb;
      end
    end
  end
endmodule

// File: rtl/dim_out_stage.sv
module dim_out_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ilv,
  input  logic         late_pick,
  input  logic         ph_q,
  input  logic         pick,
  input  logic [W-1:0] ia,
  input  logic [W-1:0] ib,
  output logic [W-1:0] dac_q
);
  logic ph2, s1, s2, choose_b, rst_d;

  always_comb begin
    if (ilv)            choose_b = ph2;
    else if (late_pick) choose_b = s1;
    else                choose_b = s2;
  end

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      ph2   <= 1'b0;
      s1    <= 1'b0;
      s2    <= 1'b0;
      dac_q <= '0;
    end else begin
      ph2   <= ph_q;
      s1    <= pick;
      s2    <= s1;
      dac_q <= choose_b ? ib : ia;
    end
  end

  always @(negedge clk) begin
    if (rst_d === 1'b1) begin
      AST_RESET_ZERO: assert (dac_q == '0); // R2
    end
  end
endmodule

// File: rtl/dac_interleave_mux.sv
module dac_interleave_mux
  import dim_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_in,
  input  logic         rst_pol,
  input  logic [2:0]   mode_sel,
  input  logic         div_in,
  input  logic         pick_b,
  input  logic [W-1:0] a_data,
  input  logic [W-1:0] b_data,
  output logic [W-1:0] dac_word,
  output logic         div_out,
  output logic         div_out_en
);
  localparam int AGE_MAX = 5;

  mode_e        mode;
  logic         rst, ilv, late_pick, ph_q, div_q;
  logic [W-1:0] ia, ib;
  logic [2:0]   age;

  assign rst       = rst_pol ? ~rst_in : rst_in;
  assign mode      = decode_mode(mode_sel);
  assign ilv       = (mode == MD_ILV_EXPORT) || (mode == MD_ILV_SELF) || (mode == MD_ILV_EXT);
  assign late_pick = (mode == MD_PICK_LATE);

  assign div_out_en = (mode == MD_ILV_EXPORT);
  assign div_out    = div_out_en & div_q;

  dim_phase_gen u_phase (
    .clk(clk), .rst(rst), .mode(mode), .div_in(div_in),
    .ph_q(ph_q), .div_q(div_q)
  );

  dim_capture #(.W(W)) u_cap (
    .clk(clk), .rst(rst), .ilv(ilv), .ph_q(ph_q),
    .a_in(a_data), .b_in(b_data), .ia(ia), .ib(ib)
  );

  dim_out_stage #(.W(W)) u_out (
    .clk(clk), .rst(rst), .ilv(ilv), .late_pick(late_pick), .ph_q(ph_q),
    .pick(pick_b), .ia(ia), .ib(ib), .dac_q(dac_word)
  );

  always_ff @(posedge clk) begin
    if (rst)                 age <= '0;
    else if (age != AGE_MAX) age <= age + 3'd1;
  end

  AST_A_PATH: assert property (@(posedge clk) disable iff (rst)
    (age == AGE_MAX && ilv && $past(ph_q, 2) == 1'b0)
      |-> (dac_word == $past(a_data, 3))); // R6

  AST_B_PATH: assert property (@(posedge clk) disable iff (rst)
    (age == AGE_MAX && ilv && $past(ph_q, 3) == 1'b0 && $past(ph_q, 2) == 1'b1)
      |-> (dac_word == $past(b_data, 4))); // R6

  AST_EARLY_PICK: assert property (@(posedge clk) disable iff (rst)
    (age == AGE_MAX && mode == MD_PICK_EARLY)
      |-> (dac_word == ($past(pick_b, 3) ? $past(b_data, 3) : $past(a_data, 3)))); // R9

  AST_LATE_PICK: assert property (@(posedge clk) disable iff (rst)
    (age == AGE_MAX && mode == MD_PICK_LATE)
      |-> (dac_word == ($past(pick_b, 2) ? $past(b_data, 3) : $past(a_data, 3)))); // R10
endmodule

// File: tb/dac_interleave_mux_test.sv
module dac_interleave_mux_test;
  localparam int PERIOD = 10;
  localparam int W      = 10;
  localparam int NSTEP  = 48;

  logic         clk = 1'b0;
  logic         rst_in, rst_pol, div_in, pick_b;
  logic [2:0]   mode_sel;
  logic [W-1:0] a_data, b_data, dac_word;
  logic         div_out, div_out_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [W-1:0] ha [0:NSTEP];
  logic [W-1:0] hb [0:NSTEP];
  logic         hp [0:NSTEP];
  logic         hk [0:NSTEP];

  always #(PERIOD/2) clk = ~clk;

  dac_interleave_mux #(.W(W)) uut (
    .clk(clk), .rst_in(rst_in), .rst_pol(rst_pol), .mode_sel(mode_sel),
    .div_in(div_in), .pick_b(pick_b), .a_data(a_data), .b_data(b_data),
    .dac_word(dac_word), .div_out(div_out), .div_out_en(div_out_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // kind: 0 export-ilv, 1 self-ilv, 2 ext-ilv, 3 early pick, 4 late pick (R3)
  function automatic int kind_of(input logic [2:0] c);
    case (c)
      3'b000:  return 0;
      3'b001:  return 1;
      3'b010:  return 2;
      3'b101:  return 4;
      default: return 3;
    endcase
  endfunction

  task automatic run_case(input logic [2:0] code, input logic pol, input int align);
    int kd;
    int exp_w;
    kd = kind_of(code);
    @(negedge clk);
    rst_pol  = pol;
    rst_in   = pol ? 1'b0 : 1'b1;
    mode_sel = code;
    repeat (3) @(negedge clk);
    chk(dac_word == '0, "R1 R2 dac cleared in reset", dac_word, 0);
    chk(div_out == 1'b0, "R2 div_out cleared in reset", div_out, 0);
    chk(div_out_en == (kd == 0), "R5 enable in reset", div_out_en, kd == 0);
    rst_in = pol ? 1'b1 : 1'b0;
    for (int k = 1; k <= NSTEP; k++) begin
      a_data = W'($urandom);
      b_data = W'($urandom);
      pick_b = 1'($urandom);
      if (kd == 0 || kd == 2) div_in = 1'((k + align) % 2);
      else                    div_in = 1'($urandom);
      ha[k] = a_data;
      hb[k] = b_data;
      hk[k] = pick_b;
      hp[k] = (kd == 1) ? 1'(k % 2) : div_in;
      @(posedge clk);
      @(negedge clk);
      if (kd == 0) begin
        chk(div_out_en == 1'b1, "R5 enable in export mode", div_out_en, 1);
        chk(div_out == 1'(k % 2), "R4 divider after edge", div_out, k % 2);
      end else begin
        chk(div_out_en == 1'b0 && div_out == 1'b0, "R5 export quiet",
            {div_out_en, div_out}, 0);
      end
      if (k >= 4) begin
        if (kd <= 2) begin
          exp_w = (hp[k-2] == 1'b0) ? int'(ha[k-2]) : int'(hb[k-3]);
          if (kd == 1)
            chk(dac_word == W'(exp_w), "R7 R6 self-phase interleave", dac_word, exp_w);
          else
            chk(dac_word == W'(exp_w), "R8 R6 external-phase interleave", dac_word, exp_w);
        end else if (kd == 3) begin
          exp_w = hk[k-2] ? int'(hb[k-2]) : int'(ha[k-2]);
          chk(dac_word == W'(exp_w), "R9 R3 early pick", dac_word, exp_w);
        end else begin
          exp_w = hk[k-1] ? int'(hb[k-2]) : int'(ha[k-2]);
          chk(dac_word == W'(exp_w), "R10 late pick", dac_word, exp_w);
        end
      end
    end
  endtask

  initial begin
    rst_pol = 1'b0; rst_in = 1'b1; mode_sel = 3'b000;
    div_in = 1'b0; pick_b = 1'b0; a_data = '0; b_data = '0;
    for (int c = 0; c < 8; c++) begin
      for (int p = 0; p < 2; p++) begin
        for (int al = 0; al < 2; al++) begin
          run_case(3'(c), 1'(p), al);
        end
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule